// File: doc/BRIEF.md
# Software-Refilled Translation Cache with Use and Modify Tracking

This block caches page-table mappings in front of a paged memory system. Each of its slots holds a virtual page tag, a physical page number, an access-rights code, a valid flag, and two status flags. The status flags are a modified (dirty) flag and a referenced flag. A lookup compares the incoming virtual page number against every valid slot in parallel. A hit returns the physical page number and a physical address whose page offset equals the virtual one, and it checks whether the requested kind of access is allowed. The result is combinational within the cycle of the request.

The block never walks the page table itself. A miss raises a miss code on the fault output. System software then installs the mapping through a refill port that names a slot and supplies its full contents. The status flags change at the clock edge after a permitted hit. Software can clear every referenced flag at once to build an approximate least-recently-used picture. A lookup also reports the slot's current status flags, so the flags can be observed.

Top module: `xlat_cache`

## Requirements
- R1: After a synchronous active-low reset every slot is invalid, so every lookup misses.
- R2: A lookup that matches a valid slot sets `lk_hit` in the same cycle. It returns that slot's physical page on `lk_ppn` and the physical address `{lk_ppn, lk_off}` on `lk_paddr`.
- R3: A valid lookup that matches no valid slot gives `lk_hit`=0 and `lk_fault`=1, and it leaves all stored state unchanged.
- R4: Rights codes are 0 read-only, 1 read/write, 2 read/execute and 3 read/write/execute. Access kinds on `lk_kind` are 0 read, 1 write, 2 fetch and 3 read. A read is always allowed. A write needs code 1 or 3, and a fetch needs code 2 or 3.
- R5: A hit whose access is not allowed gives `lk_fault`=2 with `lk_hit`=1. It changes neither the dirty flag nor the referenced flag. A permitted hit gives `lk_fault`=0.
- R6: A permitted hit sets the slot's referenced flag at the next edge. `lk_ref` and `lk_dirty` show the selected slot's flags as stored before that edge.
- R7: A permitted write hit sets the slot's dirty flag at the next edge. Reads and fetches do not change it.
- R8: `clr_ref` clears every referenced flag at the next edge. A permitted hit in the same cycle still leaves its own slot's flag set.
- R9: A refill writes the tag, page, rights and valid bit into slot `rf_idx` and clears that slot's dirty and referenced flags. This takes priority over a hit to the same slot in the same cycle. Writing `rf_valid`=0 invalidates the slot.
- R10: If two or more valid slots match, `lk_multi` is 1 and the lowest-numbered match is used for the outputs and the flag updates.
- R11: With `lk_valid`=0, `lk_hit`, `lk_multi` and `lk_fault` are 0 and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 22 | Virtual page number to translate |
| lk_off | input | 12 | Page offset carried into the physical address |
| lk_kind | input | 2 | Access kind (0 read, 1 write, 2 fetch, 3 read) |
| lk_hit | output | 1 | A valid slot matched |
| lk_multi | output | 1 | More than one valid slot matched |
| lk_fault | output | 2 | 0 none, 1 miss, 2 protection |
| lk_ppn | output | 20 | Physical page number of the selected slot |
| lk_paddr | output | 32 | Translated physical address |
| lk_dirty | output | 1 | Selected slot's dirty flag before update |
| lk_ref | output | 1 | Selected slot's referenced flag before update |
| rf_we | input | 1 | Refill strobe |
| rf_idx | input | 3 | Slot to overwrite |
| rf_valid | input | 1 | Valid bit to store |
| rf_vpn | input | 22 | Tag to store |
| rf_ppn | input | 20 | Physical page to store |
| rf_rights | input | 2 | Rights code to store |
| clr_ref | input | 1 | Clear all referenced flags |

## Verification
The hardest conditions to reach from the ports are the same-cycle collisions. These are a refill landing on the slot a permitted write is hitting, a bulk clear coinciding with a hit, and a duplicated tag. A duplicated tag can only exist if software loads the same page twice. The stimulus installs duplicates on purpose and times refills and clears to coincide with hits on the affected slot. A later lookup of that slot then exposes the surviving flags through `lk_dirty` and `lk_ref`. A long stretch of random traffic follows. It draws tags from a pool of six pages, so hits, misses and protection faults mix with refills and clears.

// File: rtl/xlat_pkg.sv
// Shared encodings for the translation cache.
// Assumes: 2-bit rights and access-kind codes as listed in the brief.
package xlat_pkg;
    typedef enum logic [1:0] {
        RT_RO  = 2'd0,
        RT_RW  = 2'd1,
        RT_RX  = 2'd2,
        RT_RWX = 2'd3
    } rights_t;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_READ2 = 2'd3
    } acc_t;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_MISS = 2'd1,
        FLT_PROT = 2'd2
    } fault_t;
endpackage

// File: rtl/xlat_slot.sv
// One translation slot: stored mapping, status flags and tag comparator.
// Assumes: refill dominates any use of the same slot in the same cycle;
// a use of the slot dominates the bulk clear of its referenced flag.
module xlat_slot #(
    parameter int VPN_W = 22,
    parameter int PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_valid,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic [1:0]       wr_rights,
    input  logic             use_en,
    input  logic             mark_dirty,
    input  logic             clr_ref,
    input  logic [VPN_W-1:0] probe_vpn,
    output logic             match,
    output logic [PPN_W-1:0] ppn,
    output logic [1:0]       rights,
    output logic             dirty,
    output logic             refd
);
    logic             valid_q;
    logic [VPN_W-1:0] vpn_q;

    // Mapping storage, loaded only by refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            vpn_q   <= '0;
            ppn     <= '0;
            rights  <= '0;
        end else if (wr_en) begin
            valid_q <= wr_valid;
            vpn_q   <= wr_vpn;
            ppn     <= wr_ppn;
            rights  <= wr_rights;
        end
    end

    // Dirty flag: cleared by refill, set by a permitted write.
    always_ff @(posedge clk) begin
        if (!rst_n)          dirty <= 1'b0;
        else if (wr_en)      dirty <= 1'b0;
        else if (mark_dirty) dirty <= 1'b1;
    end

    // Referenced flag: cleared by refill or bulk clear, set on use.
    always_ff @(posedge clk) begin
        if (!rst_n)       refd <= 1'b0;
        else if (wr_en)   refd <= 1'b0;
        else if (use_en)  refd <= 1'b1;
        else if (clr_ref) refd <= 1'b0;
    end

    // Tag comparison against the lookup page.
    always_comb match = valid_q && (vpn_q == probe_vpn);
endmodule

// File: rtl/xlat_pick.sv
// Priority picker: lowest-numbered set bit, any-match and multi-match.
// Assumes: N >= 2.
module xlat_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0]         req,
    output logic [$clog2(N)-1:0] idx,
    output logic                 any,
    output logic                 multi
);
    localparam int IW = $clog2(N);

    // Scan from the top so the lowest match is the last to assign.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    // Population flags.
    always_comb begin
        any   = |req;
        multi = ($countones(req) > 1);
    end
endmodule

// File: rtl/xlat_perm.sv
// Access-rights check for one access kind against one rights code.
// Assumes: encodings from xlat_pkg; reads are always allowed.
module xlat_perm
    import xlat_pkg::*;
(
    input  logic [1:0] rights,
    input  logic [1:0] kind,
    output logic       allow
);
    // Decode permission per access kind.
    always_comb begin
        unique case (acc_t'(kind))
            ACC_WRITE: allow = (rights_t'(rights) == RT_RW) || (rights_t'(rights) == RT_RWX);
            ACC_FETCH: allow = (rights_t'(rights) == RT_RX) || (rights_t'(rights) == RT_RWX);
            default:   allow = 1'b1;
        endcase
    end
endmodule

// File: rtl/xlat_cache.sv
// Fully associative translation cache refilled by software.
// Assumes: lookups are answered combinationally; flag and storage
// updates take effect at the next rising edge; misses are reported,
// never resolved, by this block.
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 22,
    parameter int PPN_W   = 20,
    parameter int OFF_W   = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lk_valid,
    input  logic [VPN_W-1:0]           lk_vpn,
    input  logic [OFF_W-1:0]           lk_off,
    input  logic [1:0]                 lk_kind,
    output logic                       lk_hit,
    output logic                       lk_multi,
    output logic [1:0]                 lk_fault,
    output logic [PPN_W-1:0]           lk_ppn,
    output logic [PPN_W+OFF_W-1:0]     lk_paddr,
    output logic                       lk_dirty,
    output logic                       lk_ref,
    input  logic                       rf_we,
    input  logic [$clog2(ENTRIES)-1:0] rf_idx,
    input  logic                       rf_valid,
    input  logic [VPN_W-1:0]           rf_vpn,
    input  logic [PPN_W-1:0]           rf_ppn,
    input  logic [1:0]                 rf_rights,
    input  logic                       clr_ref
);
    localparam int IW = $clog2(ENTRIES);

    logic [ENTRIES-1:0] match_vec;
    logic [ENTRIES-1:0] dirty_vec;
    logic [ENTRIES-1:0] ref_vec;
    logic [ENTRIES-1:0] use_vec;
    logic [PPN_W-1:0]   slot_ppn    [ENTRIES];
    logic [1:0]         slot_rights [ENTRIES];
    logic [IW-1:0]      sel_idx;
    logic               any_match;
    logic               multi_match;
    logic               allow;
    logic               permitted;

    // One storage slot per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        xlat_slot #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (rf_we && (rf_idx == IW'(g))),
            .wr_valid   (rf_valid),
            .wr_vpn     (rf_vpn),
            .wr_ppn     (rf_ppn),
            .wr_rights  (rf_rights),
            .use_en     (use_vec[g]),
            .mark_dirty (use_vec[g] && (acc_t'(lk_kind) == ACC_WRITE)),
            .clr_ref    (clr_ref),
            .probe_vpn  (lk_vpn),
            .match      (match_vec[g]),
            .ppn        (slot_ppn[g]),
            .rights     (slot_rights[g]),
            .dirty      (dirty_vec[g]),
            .refd       (ref_vec[g])
        );
    end

    xlat_pick #(.N(ENTRIES)) u_pick (
        .req   (match_vec),
        .idx   (sel_idx),
        .any   (any_match),
        .multi (multi_match)
    );

    xlat_perm u_perm (
        .rights (slot_rights[sel_idx]),
        .kind   (lk_kind),
        .allow  (allow)
    );

    // Qualify the hit with the request and pick the slot that is used.
    always_comb begin
        permitted = lk_valid && any_match && allow;
        for (int i = 0; i < ENTRIES; i++) begin
            use_vec[i] = permitted && (sel_idx == IW'(i));
        end
    end

    // Drive the lookup result from the selected slot.
    always_comb begin
        lk_hit   = lk_valid && any_match;
        lk_multi = lk_valid && multi_match;
        lk_ppn   = slot_ppn[sel_idx];
        lk_paddr = {slot_ppn[sel_idx], lk_off};
        lk_dirty = dirty_vec[sel_idx];
        lk_ref   = ref_vec[sel_idx];
        if (!lk_valid)       lk_fault = FLT_NONE;
        else if (!any_match) lk_fault = FLT_MISS;
        else if (!allow)     lk_fault = FLT_PROT;
        else                 lk_fault = FLT_NONE;
    end
endmodule

// File: rtl/xlat_checks.sv
// Property checker for xlat_cache, attached by bind.
// Assumes: it observes internal flag vectors and the selected index.
module xlat_checks #(
    parameter int ENTRIES = 8,
    parameter int PPN_W   = 20,
    parameter int OFF_W   = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       lk_valid,
    input logic [OFF_W-1:0]           lk_off,
    input logic [1:0]                 lk_kind,
    input logic                       lk_hit,
    input logic                       lk_multi,
    input logic [1:0]                 lk_fault,
    input logic [PPN_W+OFF_W-1:0]     lk_paddr,
    input logic                       rf_we,
    input logic [$clog2(ENTRIES)-1:0] rf_idx,
    input logic                       clr_ref,
    input logic [ENTRIES-1:0]         dirty_vec,
    input logic [ENTRIES-1:0]         ref_vec,
    input logic [$clog2(ENTRIES)-1:0] sel_idx
);
    // R2: page offset passes through untouched on a hit.
    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[OFF_W-1:0] == lk_off);

    // R3: a requested lookup without a match reports a miss.
    a_r3_miss_code: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit) |-> lk_fault == 2'd1);

    // R5: a protection fault leaves the dirty flags alone.
    a_r5_prot_no_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_fault == 2'd2 && !rf_we) |=> $stable(dirty_vec));

    // R7: a permitted write hit marks its slot dirty.
    a_r7_write_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_fault == 2'd0 && lk_kind == 2'd1 && !(rf_we && rf_idx == sel_idx))
        |=> dirty_vec[$past(sel_idx)]);

    // R8: bulk clear with no use and no refill empties all referenced flags.
    a_r8_bulk_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ref && !lk_valid && !rf_we) |=> ref_vec == '0);

    // R9: a refilled slot starts with both flags cleared.
    a_r9_refill_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> (!dirty_vec[$past(rf_idx)] && !ref_vec[$past(rf_idx)]));

    // R10: multi-hit can only accompany a hit.
    a_r10_multi_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |-> lk_hit);

    // R11: no request, no result.
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_multi && lk_fault == 2'd0));
endmodule

bind xlat_cache xlat_checks #(
    .ENTRIES (ENTRIES),
    .PPN_W   (PPN_W),
    .OFF_W   (OFF_W)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_off    (lk_off),
    .lk_kind   (lk_kind),
    .lk_hit    (lk_hit),
    .lk_multi  (lk_multi),
    .lk_fault  (lk_fault),
    .lk_paddr  (lk_paddr),
    .rf_we     (rf_we),
    .rf_idx    (rf_idx),
    .clr_ref   (clr_ref),
    .dirty_vec (dirty_vec),
    .ref_vec   (ref_vec),
    .sel_idx   (sel_idx)
);

// File: tb/sim_xlat_cache.sv
// Bench: behavioural reference model compared against the block every cycle.
module sim_xlat_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [21:0] lk_vpn = '0;
    logic [11:0] lk_off = '0;
    logic [1:0]  lk_kind = '0;
    logic        lk_hit, lk_multi, lk_dirty, lk_ref;
    logic [1:0]  lk_fault;
    logic [19:0] lk_ppn;
    logic [31:0] lk_paddr;
    logic        rf_we = 1'b0;
    logic [2:0]  rf_idx = '0;
    logic        rf_valid = 1'b0;
    logic [21:0] rf_vpn = '0;
    logic [19:0] rf_ppn = '0;
    logic [1:0]  rf_rights = '0;
    logic        clr_ref = 1'b0;

    int checks = 0;
    int errors = 0;

    // Reference model state.
    bit          m_v  [8];
    int unsigned m_vpn[8];
    int unsigned m_ppn[8];
    int unsigned m_rt [8];
    bit          m_d  [8];
    bit          m_r  [8];

    always #2 clk = ~clk;

    xlat_cache u0 (.*);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit allowed(int unsigned rt, int kind);
        if (kind == 1) return (rt == 1 || rt == 3);
        if (kind == 2) return (rt == 2 || rt == 3);
        return 1'b1;
    endfunction

    // Compare outputs now, then advance the model across the next edge.
    task automatic step();
        int sel = -1;
        int n = 0;
        bit ok;
        #1;
        for (int i = 0; i < 8; i++)
            if (m_v[i] && m_vpn[i] == lk_vpn) begin
                n++;
                if (sel < 0) sel = i;
            end
        ok = (sel >= 0) && allowed(m_rt[sel], lk_kind);
        if (!lk_valid) begin
            chk("R11 hit", lk_hit, 0);
            chk("R11 multi", lk_multi, 0);
            chk("R11 fault", lk_fault, 0);
        end else if (sel < 0) begin
            chk("R3 hit", lk_hit, 0);
            chk("R3 fault", lk_fault, 1);
        end else begin
            chk("R2 hit", lk_hit, 1);
            chk("R2 ppn", lk_ppn, m_ppn[sel]);
            chk("R2 paddr", lk_paddr, {m_ppn[sel][19:0], lk_off});
            chk("R10 multi", lk_multi, n > 1);
            chk("R4 R5 fault", lk_fault, ok ? 0 : 2);
            chk("R6 ref", lk_ref, m_r[sel]);
            chk("R7 dirty", lk_dirty, m_d[sel]);
        end
        @(posedge clk);
        if (clr_ref) for (int i = 0; i < 8; i++) m_r[i] = 0;
        if (lk_valid && ok) begin
            m_r[sel] = 1;
            if (lk_kind == 1) m_d[sel] = 1;
        end
        if (rf_we) begin
            m_v[rf_idx] = rf_valid;
            m_vpn[rf_idx] = rf_vpn;
            m_ppn[rf_idx] = rf_ppn;
            m_rt[rf_idx] = rf_rights;
            m_d[rf_idx] = 0;
            m_r[rf_idx] = 0;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        lk_valid = 0; rf_we = 0; clr_ref = 0;
    endtask

    task automatic look(int unsigned vpn, int kind, int off);
        idle();
        lk_valid = 1; lk_vpn = 22'(vpn); lk_kind = 2'(kind); lk_off = 12'(off);
        step();
    endtask

    task automatic fill(int idx, int unsigned vpn, int unsigned ppn, int rt, bit v);
        idle();
        rf_we = 1; rf_idx = 3'(idx); rf_vpn = 22'(vpn); rf_ppn = 20'(ppn);
        rf_rights = 2'(rt); rf_valid = v;
        step();
    endtask

    initial begin : watchdog
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < 8; i++) begin
            m_v[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_rt[i] = 0; m_d[i] = 0; m_r[i] = 0;
        end
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: after reset everything misses, including the all-zero page.
        look(0, 0, 0);
        look(22'h3fffff, 1, 5);
        // R9: install all slots with each rights code.
        for (int i = 0; i < 8; i++) fill(i, 32'h100 + i, 32'h8000 + 16 * i, i % 4, 1);
        // R2 R4 R6: every slot, every access kind.
        for (int i = 0; i < 8; i++)
            for (int k = 0; k < 4; k++) look(32'h100 + i, k, 12'h0a5 + k);
        // R5: write to read-only slot 0 faults and changes nothing.
        look(32'h100, 1, 1);
        look(32'h100, 0, 2);
        // R7: repeated write on slot 1 shows dirty on the second.
        look(32'h101, 1, 3);
        look(32'h101, 1, 4);
        // R8: bulk clear while idle, then clear coinciding with a hit on slot 3.
        idle(); clr_ref = 1; step();
        look(32'h102, 0, 0);
        idle(); lk_valid = 1; lk_vpn = 22'h103; lk_kind = 0; clr_ref = 1; step();
        look(32'h103, 0, 0);
        look(32'h102, 0, 0);
        // R9: refill colliding with a permitted write on the same slot 1.
        idle(); lk_valid = 1; lk_vpn = 22'h101; lk_kind = 1;
        rf_we = 1; rf_idx = 1; rf_vpn = 22'h101; rf_ppn = 20'h12345; rf_rights = 1; rf_valid = 1;
        step();
        look(32'h101, 0, 7);
        // R10: duplicate tag in slots 2 and 6; lowest wins.
        fill(6, 32'h102, 32'hbeef, 3, 1);
        look(32'h102, 1, 9);
        look(32'h102, 0, 9);
        // R9: invalidating slot 2 exposes slot 6.
        fill(2, 32'h102, 0, 0, 0);
        look(32'h102, 0, 9);
        // R11: idle cycle with a matching page on the bus.
        idle(); lk_vpn = 22'h104; step();
        // Random mix over a small page pool.
        for (int t = 0; t < 3000; t++) begin
            idle();
            lk_valid = ($urandom % 4) != 0;
            lk_vpn   = 22'(32'h200 + $urandom % 6);
            lk_kind  = 2'($urandom);
            lk_off   = 12'($urandom);
            rf_we    = ($urandom % 5) == 0;
            rf_idx   = 3'($urandom);
            rf_vpn   = 22'(32'h200 + $urandom % 6);
            rf_ppn   = 20'($urandom);
            rf_rights = 2'($urandom);
            rf_valid = ($urandom % 8) != 0;
            clr_ref  = ($urandom % 16) == 0;
            step();
        end
        idle(); step();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule